// File: doc/BRIEF.md
# Bias, activation and quantize pipeline

This block is the output stage of an integer inference engine. It takes a signed 32-bit accumulator value and produces a signed 8-bit result. The value passes through three registered steps, one per stage:

- A signed 8-bit bias is added to the value.
- One of three activations is applied: pass-through, rectifier, or a leaky rectifier whose negative slope is one eighth.
- The value is arithmetically shifted right by a programmable amount from 0 to 31, then clamped to the signed 8-bit range.

A sequencer feeds the block one value at a time, or as a back-to-back stream, using a valid/ready handshake. It reads the result the same way. A status path watches the `empty` output to learn when nothing is left in flight.

The bias, shift and activation inputs are read live by the stage that uses them. They must therefore be held stable while `empty` is low.

All three stages share one advance condition. The pipeline moves whenever the output register is free or is being read in the current cycle. Otherwise every stage holds its contents, and `in_ready` tells the producer that its input is not being taken.

Top module: `qnt_postproc`

## Requirements
- R1: After reset, `out_valid` is 0, `empty` is 1 and `in_ready` is 1.
- R2: An input accepted (`in_valid` and `in_ready` high) at a clock edge appears at `out_valid`/`out_data` after exactly three rising edges, provided `out_ready` stays high. A new input may be accepted every cycle, giving one result per cycle in order.
- R3: The bias is sign-extended and added to the sign-extended input in 33 bits, so the sum never wraps. For example, 0x7FFFFFFF plus bias 127 with shift 31 and mode 00 yields +1.
- R4: `act_mode` 2'b00 and 2'b11 both pass the biased value through unchanged.
- R5: `act_mode` 2'b01 replaces a negative biased value with 0 and leaves non-negative values unchanged. For example, input 2, bias 0, shift 0 yields 2.
- R6: `act_mode` 2'b10 replaces a negative biased value with its arithmetic right shift by 3, which rounds toward negative infinity (-9 becomes -2). Non-negative values are unchanged.
- R7: The activated value is arithmetically shifted right by `quant_shift` (0 to 31), which preserves its sign. For example, -256 shifted by 4 is -16.
- R8: After the shift, values above 127 give 127, values below -128 give -128, and values in range are passed as their low 8 bits.
- R9: While `out_valid` is 1 and `out_ready` is 0:
  - `out_valid` and `out_data` hold.
  - `in_ready` is 0.
  - Any `in_valid` is ignored, so that value never reaches the output.
- R10: `empty` is 1 exactly when no stage holds valid data. It drops in the cycle after an input is accepted and returns to 1 once the last result has been read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 32 | Signed accumulator value |
| in_valid | input | 1 | `in_data` is offered |
| in_ready | output | 1 | Input is taken at this edge when `in_valid` is high |
| bias | input | 8 | Signed bias added in stage one |
| quant_shift | input | 5 | Arithmetic right-shift amount used in stage three |
| act_mode | input | 2 | 00 none, 01 rectifier, 10 leaky rectifier, 11 none |
| out_data | output | 8 | Signed saturated result |
| out_valid | output | 1 | `out_data` holds a result |
| out_ready | input | 1 | Consumer takes `out_data` at this edge |
| empty | output | 1 | No stage holds valid data |

## Verification
On every cycle, the assertions check the handshake side of the pipeline:
- a held result stays frozen while the consumer stalls;
- `empty` never coexists with a valid output;
- an accepted input always clears `empty`;
- an idle pipeline with no input stays empty.

The arithmetic can only be shown by the bench's directed scenarios. Each scenario compares results against a model built from the requirements. The scenarios cover the sign handling of the 33-bit bias sum, the three activations including the floor rounding of the leaky slope, the arithmetic shift and both saturation limits. The scenarios also show the exact three-edge latency, in-order streaming, and the fact that an input offered during a stall never appears.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'b00,
    ACT_RELU  = 2'b01,
    ACT_LEAKY = 2'b10,
    ACT_SPARE = 2'b11
  } act_mode_e;
endpackage

// File: rtl/pp_bias_stage.sv
module pp_bias_stage #(
  parameter int ACC_W  = 32,
  parameter int BIAS_W = 8,
  parameter int SUM_W  = ACC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              in_valid,
  input  logic [ACC_W-1:0]  in_data,
  input  logic [BIAS_W-1:0] bias,
  output logic              v_q,
  output logic [SUM_W-1:0]  sum_q
);
  localparam int AEXT = SUM_W - ACC_W;
  localparam int BEXT = SUM_W - BIAS_W;

  logic [SUM_W-1:0] sum_d;
  logic             load;

  always_comb begin
    sum_d = {{AEXT{in_data[ACC_W-1]}}, in_data} + {{BEXT{bias[BIAS_W-1]}}, bias};
    load  = adv & in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      sum_q <= '0;
    end else begin
      if (adv)  v_q   <= in_valid;
      if (load) sum_q <= sum_d;
    end
  end
endmodule

// File: rtl/pp_act_stage.sv
module pp_act_stage #(
  parameter int SUM_W    = 33,
  parameter int LEAKY_SH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             in_valid,
  input  logic [SUM_W-1:0] in_data,
  input  logic [1:0]       act_mode,
  output logic             v_q,
  output logic [SUM_W-1:0] act_q
);
  import pp_pkg::*;

  act_mode_e               mode;
  logic signed [SUM_W-1:0] val;
  logic [SUM_W-1:0]        act_d;
  logic                    neg;
  logic                    load;

  always_comb begin
    mode  = act_mode_e'(act_mode);
    val   = $signed(in_data);
    neg   = in_data[SUM_W-1];
    act_d = in_data;
    unique case (mode)
      ACT_RELU:  if (neg) act_d = '0;
      ACT_LEAKY: if (neg) act_d = val >>> LEAKY_SH;
      default:   act_d = in_data;
    endcase
    load = adv & in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      act_q <= '0;
    end else begin
      if (adv)  v_q   <= in_valid;
      if (load) act_q <= act_d;
    end
  end
endmodule

// File: rtl/pp_quant_stage.sv
module pp_quant_stage #(
  parameter int SUM_W   = 33,
  parameter int OUT_W   = 8,
  parameter int SHIFT_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic               in_valid,
  input  logic [SUM_W-1:0]   in_data,
  input  logic [SHIFT_W-1:0] quant_shift,
  output logic               v_q,
  output logic [OUT_W-1:0]   q_q
);
  localparam int TOP = SUM_W - 1;
  localparam int MSB = OUT_W - 1;

  logic signed [SUM_W-1:0] val;
  logic [SUM_W-1:0]        shifted;
  logic                    fits;
  logic [OUT_W-1:0]        q_d;
  logic                    load;

  always_comb begin
    val     = $signed(in_data);
    shifted = val >>> quant_shift;
    fits    = (&shifted[TOP:MSB]) | ~(|shifted[TOP:MSB]);
    if (fits)
      q_d = shifted[MSB:0];
    else if (shifted[TOP])
      q_d = {1'b1, {MSB{1'b0}}};
    else
      q_d = {1'b0, {MSB{1'b1}}};
    load = adv & in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      q_q <= '0;
    end else begin
      if (adv)  v_q <= in_valid;
      if (load) q_q <= q_d;
    end
  end
endmodule

// File: rtl/qnt_postproc.sv
module qnt_postproc #(
  parameter int ACC_W    = 32,
  parameter int BIAS_W   = 8,
  parameter int OUT_W    = 8,
  parameter int SHIFT_W  = 5,
  parameter int LEAKY_SH = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ACC_W-1:0]   in_data,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [BIAS_W-1:0]  bias,
  input  logic [SHIFT_W-1:0] quant_shift,
  input  logic [1:0]         act_mode,
  output logic [OUT_W-1:0]   out_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               empty
);
  localparam int SUM_W = ACC_W + 1;

  logic             adv;
  logic             v1, v2, v3;
  logic [SUM_W-1:0] s1_sum;
  logic [SUM_W-1:0] s2_act;

  always_comb begin
    adv       = ~v3 | out_ready;
    in_ready  = adv;
    out_valid = v3;
    empty     = ~(v1 | v2 | v3);
  end

  pp_bias_stage #(.ACC_W(ACC_W), .BIAS_W(BIAS_W), .SUM_W(SUM_W)) u_bias (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_valid(in_valid),
    .in_data(in_data), .bias(bias), .v_q(v1), .sum_q(s1_sum)
  );

  pp_act_stage #(.SUM_W(SUM_W), .LEAKY_SH(LEAKY_SH)) u_act (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_valid(v1),
    .in_data(s1_sum), .act_mode(act_mode), .v_q(v2), .act_q(s2_act)
  );

  pp_quant_stage #(.SUM_W(SUM_W), .OUT_W(OUT_W), .SHIFT_W(SHIFT_W)) u_quant (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_valid(v2),
    .in_data(s2_act), .quant_shift(quant_shift), .v_q(v3), .q_q(out_data)
  );
endmodule

// File: rtl/qnt_postproc_chk.sv
module qnt_postproc_chk #(
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data,
  input logic             empty
);
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_valid_not_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !empty);

  assert_accept_fills_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !empty);

  assert_idle_stays_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !in_valid) |=> empty);
endmodule

bind qnt_postproc qnt_postproc_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .empty(empty)
);

// File: tb/test_qnt_postproc.sv
`timescale 1ns/1ps
module test_qnt_postproc;
  logic        clk;
  logic        rst_n;
  logic [31:0] in_data;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  bias;
  logic [4:0]  quant_shift;
  logic [1:0]  act_mode;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        out_ready;
  logic        empty;

  int n_chk;
  int n_bad;
  bit done;

  qnt_postproc i_qnt_postproc (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .bias(bias), .quant_shift(quant_shift),
    .act_mode(act_mode), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .empty(empty)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] model(int d, int b, int sh, logic [1:0] m);
    longint s;
    s = longint'(d) + longint'(b);
    if (m == 2'b01 && s < 0) s = 0;
    else if (m == 2'b10 && s < 0) s = s >>> 3;
    s = s >>> sh;
    if (s > 127) s = 127;
    if (s < -128) s = -128;
    return s[7:0];
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_one(string req, int d, int b, int sh, logic [1:0] m);
    bias = b[7:0]; quant_shift = sh[4:0]; act_mode = m;
    in_data = d; in_valid = 1'b1; out_ready = 1'b1;
    step();
    in_valid = 1'b0;
    chk("R10", "empty after accept", {31'd0, empty}, 32'd0);
    step();
    chk("R2", "out_valid before third edge", {31'd0, out_valid}, 32'd0);
    step();
    chk("R2", "out_valid at third edge", {31'd0, out_valid}, 32'd1);
    chk(req, "result", {24'd0, out_data}, {24'd0, model(d, b, sh, m)});
    step();
    chk("R10", "empty after drain", {31'd0, empty}, 32'd1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    bias = '0; quant_shift = '0; act_mode = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R1", "out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1", "empty", {31'd0, empty}, 32'd1);
    chk("R1", "in_ready", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_bias();
    run_one("R3", 32'sh7FFFFFFF, 127, 31, 2'b00);
    run_one("R3", 32'sh80000000, -128, 31, 2'b00);
    run_one("R3", 100, -28, 0, 2'b00);
  endtask

  task automatic t_modes();
    run_one("R4", -50, 0, 0, 2'b00);
    run_one("R4", -50, 0, 0, 2'b11);
    run_one("R5", 2, 0, 0, 2'b01);
    run_one("R5", -7, 3, 0, 2'b01);
    run_one("R6", -9, 0, 0, 2'b10);
    run_one("R6", -8, 0, 0, 2'b10);
    run_one("R6", 40, 0, 0, 2'b10);
  endtask

  task automatic t_quant();
    run_one("R7", -256, 0, 4, 2'b00);
    run_one("R7", 1000, 0, 3, 2'b00);
    run_one("R7", -1, 0, 31, 2'b00);
    run_one("R8", 200, 0, 0, 2'b00);
    run_one("R8", -1000, 0, 0, 2'b00);
    run_one("R8", 127, 0, 0, 2'b00);
    run_one("R8", -128, 0, 0, 2'b00);
  endtask

  task automatic t_stream();
    int vals[4] = '{5, -300, 90, -20};
    bias = 8'd10; quant_shift = 5'd1; act_mode = 2'b10; out_ready = 1'b1;
    for (int k = 0; k < 7; k++) begin
      if (k >= 3) begin
        chk("R2", "stream valid", {31'd0, out_valid}, 32'd1);
        chk("R2", "stream order", {24'd0, out_data}, {24'd0, model(vals[k-3], 10, 1, 2'b10)});
      end
      if (k < 4) begin
        in_data = vals[k]; in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
      step();
    end
    chk("R2", "stream drained", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_stall();
    int vals[3] = '{11, -22, 33};
    bias = 8'd0; quant_shift = 5'd0; act_mode = 2'b00; out_ready = 1'b0;
    for (int k = 0; k < 3; k++) begin
      in_data = vals[k]; in_valid = 1'b1;
      step();
    end
    in_data = 99;
    for (int k = 0; k < 3; k++) begin
      chk("R9", "held valid", {31'd0, out_valid}, 32'd1);
      chk("R9", "held data", {24'd0, out_data}, {24'd0, model(11, 0, 0, 2'b00)});
      chk("R9", "in_ready low", {31'd0, in_ready}, 32'd0);
      step();
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    step();
    chk("R9", "second after stall", {24'd0, out_data}, {24'd0, model(-22, 0, 0, 2'b00)});
    step();
    chk("R9", "third after stall", {24'd0, out_data}, {24'd0, model(33, 0, 0, 2'b00)});
    step();
    chk("R9", "stalled input dropped", {31'd0, out_valid}, 32'd0);
    chk("R10", "empty after stall", {31'd0, empty}, 32'd1);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    @(negedge clk);
    t_reset();
    t_bias();
    t_modes();
    t_quant();
    t_stream();
    t_stall();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule